// File: doc/BRIEF.md
# Trigger Flow Statistics Unit

This unit collects running statistics for a trigger flow-control path. Every cycle it watches a pass-request strobe, an accept strobe, a busy level and an error level. It counts pass requests and accepted events. It keeps a free-running time base in clock ticks and captures that time base whenever an event is accepted. The number of triggers that were suppressed is derived on the fly, as pass requests minus accepted events.

For each of the two levels, busy and error, a duration tracker keeps three values: the total number of asserted cycles, the length of the current or most recent assertion, and the longest assertion seen. The busy and error trackers are the same logic. Every counter stops at its all-ones value instead of wrapping. A synchronous clear returns every statistic to zero. All results are plain read-only outputs, ready to be sampled by a register interface outside this block.

Top module: `trig_stats`

## Requirements
- R1: A cycle with `clr_i` high makes every count, time, duration and stamp output zero in the next cycle, whatever the other inputs are in that cycle.
- R2: `time_now_o` rises by one on every clock outside a clear cycle and stays at its all-ones value once it gets there.
- R3: `pass_total_o` rises by one after each cycle with `pass_i` high, saturating at all ones.
- R4: `event_num_o` rises by one after each cycle with `accept_i` high, saturating at all ones.
- R5: After a cycle with `accept_i` high, `accept_time_o` shows the `time_now_o` value of that cycle; otherwise it holds.
- R6: `suppressed_o` equals `pass_total_o` minus `event_num_o`, and is zero when `event_num_o` is the larger of the two.
- R7: `busy_total_o` rises by one after each cycle with `busy_i` high, saturating at all ones.
- R8: `busy_cur_o` becomes 1 after the first high cycle of a busy assertion, which is a high cycle following a low cycle or a clear. It rises by one after each further high cycle, saturating at all ones, and holds while `busy_i` is low.
- R9: `busy_max_o` takes the new `busy_cur_o` value whenever that value exceeds it, so it never falls below `busy_cur_o`.
- R10: `err_total_o`, `err_cur_o` and `err_max_o` follow rules R7 to R9 for `err_i`.
- R11: While reset is applied, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all statistics |
| pass_i | input | 1 | Pass-request strobe, one count per high cycle |
| accept_i | input | 1 | Accept strobe, one event per high cycle |
| busy_i | input | 1 | Busy level |
| err_i | input | 1 | Error level |
| pass_total_o | output | CNT_W | Pass requests counted |
| event_num_o | output | CNT_W | Accepted events counted |
| suppressed_o | output | CNT_W | Pass requests minus accepted events |
| time_now_o | output | TIME_W | Free-running time base |
| accept_time_o | output | TIME_W | Time base captured at the last accept |
| busy_total_o | output | DUR_W | Total busy cycles |
| busy_cur_o | output | DUR_W | Length of current or last busy assertion |
| busy_max_o | output | DUR_W | Longest busy assertion |
| err_total_o | output | DUR_W | Total error cycles |
| err_cur_o | output | DUR_W | Length of current or last error assertion |
| err_max_o | output | DUR_W | Longest error assertion |

## Verification
The bench builds the unit with CNT_W=4, TIME_W=6 and DUR_W=5. With these widths the event counters stop at 15, the time base at 63 and the durations at 31. Saturation of every counter, including a busy run longer than 31 cycles, is reached in tens of cycles. A stamp taken after the time base has saturated, and an accept count larger than the pass count, which must give a suppressed value of zero, are also reached quickly.

// File: rtl/trig_stats_pkg.sv
package trig_stats_pkg;
  localparam int CH_BUSY = 0;
  localparam int CH_ERR  = 1;
  localparam int NUM_CH  = 2;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/trig_sat_ctr.sv
module trig_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != TOP));
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q = cnt_q;
endmodule

// File: rtl/trig_dur_track.sv
module trig_dur_track #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         lvl,
  output logic [W-1:0] total,
  output logic [W-1:0] cur,
  output logic [W-1:0] peak
);
  localparam logic [W-1:0] TOP = '1;

  logic         prev_q;
  logic [W-1:0] cur_q, cur_d;
  logic [W-1:0] peak_q, peak_d;
  logic         upd_en;

  trig_sat_ctr #(.W(W)) u_total (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .inc  (lvl),
    .q    (total)
  );

  always_comb begin
    upd_en = clr | lvl;
    cur_d  = cur_q;
    peak_d = peak_q;
    if (clr) begin
      cur_d  = '0;
      peak_d = '0;
    end else if (lvl) begin
      if (!prev_q)            cur_d = W'(1);
      else if (cur_q != TOP)  cur_d = cur_q + W'(1);
      if (cur_d > peak_q)     peak_d = cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cur_q  <= '0;
      peak_q <= '0;
    end else begin
      prev_q <= lvl & ~clr;
      if (upd_en) begin
        cur_q  <= cur_d;
        peak_q <= peak_d;
      end
    end
  end

  assign cur  = cur_q;
  assign peak = peak_q;
endmodule

// File: rtl/trig_stats.sv
module trig_stats
  import trig_stats_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              pass_i,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              err_i,
  output logic [CNT_W-1:0]  pass_total_o,
  output logic [CNT_W-1:0]  event_num_o,
  output logic [CNT_W-1:0]  suppressed_o,
  output logic [TIME_W-1:0] time_now_o,
  output logic [TIME_W-1:0] accept_time_o,
  output logic [DUR_W-1:0]  busy_total_o,
  output logic [DUR_W-1:0]  busy_cur_o,
  output logic [DUR_W-1:0]  busy_max_o,
  output logic [DUR_W-1:0]  err_total_o,
  output logic [DUR_W-1:0]  err_cur_o,
  output logic [DUR_W-1:0]  err_max_o
);
  logic srst_n;

  trig_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  trig_sat_ctr #(.W(TIME_W)) u_time (
    .clk  (clk), .rst_n(srst_n), .clr(clr_i), .inc(1'b1), .q(time_now_o)
  );

  trig_sat_ctr #(.W(CNT_W)) u_pass (
    .clk  (clk), .rst_n(srst_n), .clr(clr_i), .inc(pass_i), .q(pass_total_o)
  );

  trig_sat_ctr #(.W(CNT_W)) u_evt (
    .clk  (clk), .rst_n(srst_n), .clr(clr_i), .inc(accept_i), .q(event_num_o)
  );

  // accept timestamp
  logic [TIME_W-1:0] stamp_q, stamp_d;
  logic              stamp_en;

  always_comb begin
    stamp_en = clr_i | accept_i;
    stamp_d  = clr_i ? '0 : time_now_o;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       stamp_q <= '0;
    else if (stamp_en) stamp_q <= stamp_d;
  end

  assign accept_time_o = stamp_q;

  // suppressed triggers, clamped at zero
  assign suppressed_o = (pass_total_o >= event_num_o) ? (pass_total_o - event_num_o) : '0;

  // duration trackers, one per level input
  logic [NUM_CH-1:0] lvl;
  logic [DUR_W-1:0]  tot_w  [NUM_CH];
  logic [DUR_W-1:0]  cur_w  [NUM_CH];
  logic [DUR_W-1:0]  peak_w [NUM_CH];

  assign lvl[CH_BUSY] = busy_i;
  assign lvl[CH_ERR]  = err_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    trig_dur_track #(.W(DUR_W)) u_dur (
      .clk  (clk),
      .rst_n(srst_n),
      .clr  (clr_i),
      .lvl  (lvl[g]),
      .total(tot_w[g]),
      .cur  (cur_w[g]),
      .peak (peak_w[g])
    );
  end

  assign busy_total_o = tot_w[CH_BUSY];
  assign busy_cur_o   = cur_w[CH_BUSY];
  assign busy_max_o   = peak_w[CH_BUSY];
  assign err_total_o  = tot_w[CH_ERR];
  assign err_cur_o    = cur_w[CH_ERR];
  assign err_max_o    = peak_w[CH_ERR];
endmodule

// File: rtl/trig_stats_chk.sv
module trig_stats_chk #(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32,
  parameter int DUR_W  = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              clr_i,
  input logic              pass_i,
  input logic              accept_i,
  input logic              busy_i,
  input logic              err_i,
  input logic [CNT_W-1:0]  pass_total_o,
  input logic [CNT_W-1:0]  event_num_o,
  input logic [CNT_W-1:0]  suppressed_o,
  input logic [TIME_W-1:0] time_now_o,
  input logic [TIME_W-1:0] accept_time_o,
  input logic [DUR_W-1:0]  busy_cur_o,
  input logic [DUR_W-1:0]  busy_max_o,
  input logic [DUR_W-1:0]  busy_total_o,
  input logic [DUR_W-1:0]  err_cur_o,
  input logic [DUR_W-1:0]  err_max_o
);
  localparam logic [TIME_W-1:0] T_TOP = '1;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clr_i |=> (pass_total_o == '0 && event_num_o == '0 && time_now_o == '0 &&
               accept_time_o == '0 && busy_total_o == '0 && busy_max_o == '0 &&
               err_max_o == '0));

  // R2
  time_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && time_now_o != T_TOP) |=> time_now_o == TIME_W'($past(time_now_o) + TIME_W'(1)));

  // R3
  pass_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && !pass_i) |=> $stable(pass_total_o));

  // R4
  evt_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && !accept_i) |=> $stable(event_num_o));

  // R5
  stamp_take_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && accept_i) |=> accept_time_o == $past(time_now_o));

  // R5
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && !accept_i) |=> $stable(accept_time_o));

  // R6
  supp_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    suppressed_o <= pass_total_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && !busy_i) |=> $stable(busy_cur_o));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && busy_i && !$past(busy_i)) |=> busy_cur_o == DUR_W'(1));

  // R9
  busy_peak_chk: assert property (@(posedge clk) disable iff (!srst_n)
    busy_max_o >= busy_cur_o);

  // R10
  err_peak_chk: assert property (@(posedge clk) disable iff (!srst_n)
    err_max_o >= err_cur_o);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_i && !err_i) |=> $stable(err_cur_o));
endmodule

bind trig_stats trig_stats_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W), .DUR_W(DUR_W)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .clr_i        (clr_i),
  .pass_i       (pass_i),
  .accept_i     (accept_i),
  .busy_i       (busy_i),
  .err_i        (err_i),
  .pass_total_o (pass_total_o),
  .event_num_o  (event_num_o),
  .suppressed_o (suppressed_o),
  .time_now_o   (time_now_o),
  .accept_time_o(accept_time_o),
  .busy_cur_o   (busy_cur_o),
  .busy_max_o   (busy_max_o),
  .busy_total_o (busy_total_o),
  .err_cur_o    (err_cur_o),
  .err_max_o    (err_max_o)
);

// File: tb/trig_stats_test.sv
`timescale 1ns/1ps
module trig_stats_test;
  localparam int CW = 4;
  localparam int TW = 6;
  localparam int DW = 5;
  localparam int CMAX = (1 << CW) - 1;
  localparam int TMAX = (1 << TW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n, clr_i, pass_i, accept_i, busy_i, err_i;
  logic [CW-1:0] pass_total_o, event_num_o, suppressed_o;
  logic [TW-1:0] time_now_o, accept_time_o;
  logic [DW-1:0] busy_total_o, busy_cur_o, busy_max_o, err_total_o, err_cur_o, err_max_o;

  always #5 clk = ~clk;

  trig_stats #(.CNT_W(CW), .TIME_W(TW), .DUR_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .pass_i(pass_i), .accept_i(accept_i),
    .busy_i(busy_i), .err_i(err_i),
    .pass_total_o(pass_total_o), .event_num_o(event_num_o), .suppressed_o(suppressed_o),
    .time_now_o(time_now_o), .accept_time_o(accept_time_o),
    .busy_total_o(busy_total_o), .busy_cur_o(busy_cur_o), .busy_max_o(busy_max_o),
    .err_total_o(err_total_o), .err_cur_o(err_cur_o), .err_max_o(err_max_o)
  );

  int total = 0;
  int bad = 0;
  bit model_on = 0;
  bit done = 0;

  // reference state
  int m_time, m_pass, m_evt, m_stamp;
  int m_tot[2], m_cur[2], m_max[2];
  bit m_prev[2];
  bit m_after_clr;

  function automatic int sat(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int supp;
    supp = (m_pass >= m_evt) ? m_pass - m_evt : 0;
    chk(m_after_clr ? "R1" : "R2", "time", int'(time_now_o), m_time);
    chk(m_after_clr ? "R1" : "R3", "pass", int'(pass_total_o), m_pass);
    chk(m_after_clr ? "R1" : "R4", "event", int'(event_num_o), m_evt);
    chk(m_after_clr ? "R1" : "R5", "stamp", int'(accept_time_o), m_stamp);
    chk("R6", "suppressed", int'(suppressed_o), supp);
    chk(m_after_clr ? "R1" : "R7", "busy_total", int'(busy_total_o), m_tot[0]);
    chk(m_after_clr ? "R1" : "R8", "busy_cur", int'(busy_cur_o), m_cur[0]);
    chk(m_after_clr ? "R1" : "R9", "busy_max", int'(busy_max_o), m_max[0]);
    chk(m_after_clr ? "R1" : "R10", "err_total", int'(err_total_o), m_tot[1]);
    chk(m_after_clr ? "R1" : "R10", "err_cur", int'(err_cur_o), m_cur[1]);
    chk(m_after_clr ? "R1" : "R10", "err_max", int'(err_max_o), m_max[1]);
  endtask

  task automatic model_update(bit c, bit p, bit a, bit b, bit e);
    bit lv[2];
    lv[0] = b; lv[1] = e;
    m_after_clr = c;
    if (c) begin
      m_time = 0; m_pass = 0; m_evt = 0; m_stamp = 0;
      for (int i = 0; i < 2; i++) begin
        m_tot[i] = 0; m_cur[i] = 0; m_max[i] = 0; m_prev[i] = 0;
      end
    end else begin
      if (a) begin
        m_stamp = m_time;
        m_evt = sat(m_evt + 1, CMAX);
      end
      if (p) m_pass = sat(m_pass + 1, CMAX);
      m_time = sat(m_time + 1, TMAX);
      for (int i = 0; i < 2; i++) begin
        if (lv[i]) begin
          m_tot[i] = sat(m_tot[i] + 1, DMAX);
          m_cur[i] = m_prev[i] ? sat(m_cur[i] + 1, DMAX) : 1;
          if (m_cur[i] > m_max[i]) m_max[i] = m_cur[i];
        end
        m_prev[i] = lv[i];
      end
    end
  endtask

  task automatic step(bit c, bit p, bit a, bit b, bit e);
    @(negedge clk);
    if (model_on) compare_all();
    clr_i = c; pass_i = p; accept_i = a; busy_i = b; err_i = e;
    model_update(c, p, a, b, e);
  endtask

  initial begin
    rst_n = 1'b0;
    clr_i = 0; pass_i = 0; accept_i = 0; busy_i = 0; err_i = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "pass", int'(pass_total_o), 0);
    chk("R11", "time", int'(time_now_o), 0);
    chk("R11", "stamp", int'(accept_time_o), 0);
    chk("R11", "busy_max", int'(busy_max_o), 0);
    chk("R11", "err_total", int'(err_total_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(1, 0, 0, 0, 0);
    model_on = 1;
    // idle, time base runs (R2)
    repeat (5) step(0, 0, 0, 0, 0);
    // passes with every third accepted, pass count saturates (R3 R4 R6)
    for (int i = 0; i < 20; i++) step(0, 1, (i % 3) == 0, 0, 0);
    // clear with every input high (R1)
    step(1, 1, 1, 1, 1);
    // accepts without passes: suppressed clamps to zero (R6)
    for (int i = 0; i < 4; i++) step(0, i == 0, 1, 0, 0);
    // busy run past saturation, then shorter runs (R7 R8 R9)
    repeat (40) step(0, 0, 0, 1, 0);
    repeat (3) step(0, 0, 0, 0, 0);
    repeat (4) step(0, 0, 0, 1, 0);
    repeat (2) step(0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0);
    repeat (3) step(0, 0, 0, 1, 0);
    // error bursts 3, 7, 2 (R10)
    repeat (3) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    repeat (7) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    repeat (2) step(0, 0, 0, 0, 1);
    // time base saturates, then accept captures the top value (R2 R5)
    repeat (70) step(0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0);
    repeat (2) step(0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 2500; i++)
      step(($urandom % 60) == 0, $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 8) < 5, ($urandom % 8) < 2);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before end of stimulus");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule